// File: doc/BRIEF.md
# Register Bank Save Tracker

This block keeps count of how many hardware register banks currently hold a saved processor context. Each time the processor accepts an interrupt that stores its context into a bank, the save strobe pulses and the count rises by one. Each time a bank-restore instruction executes, the restore strobe pulses and the count falls by one. The count is bounded by the number of banks, which is a parameter.

Two exception requests come out of the tracker. A restore attempted with no saved context always raises a bank underflow request. A save that arrives with every bank already occupied raises a bank overflow request, but only when the overflow exception enable input is 1. If that input is 0, the save is silently dropped. In both error cases the count stays at its bound. Full and empty flags are decoded from the count for use by the surrounding control logic. The bank storage itself and the interrupt controller are outside this block.

Top module: `bank_save_tracker`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block is cleared. After that edge the count is 0, empty_o is 1, full_o is 0, and both exception requests are 0.
- R2: A save strobe without a restore strobe, when the count is below NUM_BANKS, raises the count by exactly one at the next edge. A cycle with neither strobe leaves the count unchanged.
- R3: A restore strobe without a save strobe, when the count is above 0, lowers the count by exactly one at the next edge.
- R4: full_o is 1 exactly when the count equals NUM_BANKS. empty_o is 1 exactly when the count equals 0.
- R5: A restore strobe without a save strobe, when the count is 0, drives ufl_req_o to 1 for the cycle after that edge, and the count stays at 0.
- R6: A save strobe without a restore strobe, when the count equals NUM_BANKS and ovf_en_i is 1, drives ovf_req_o to 1 for the cycle after that edge, and the count stays at NUM_BANKS.
- R7: A save strobe without a restore strobe, when the count equals NUM_BANKS and ovf_en_i is 0, is dropped. The count is unchanged and ovf_req_o stays 0.
- R8: When save and restore strobes arrive in the same cycle, the count is unchanged and neither request is raised, whatever the count.
- R9: Each request is 1 only in the cycle that directly follows a qualifying strobe cycle. In every other cycle it is 0, so an isolated fault gives a one-cycle pulse.
- R10: ovf_en_i is sampled together with the save strobe. It never causes an overflow request while the count is below NUM_BANKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| save_i | input | 1 | One-cycle strobe: a bank-using interrupt was accepted |
| restore_i | input | 1 | One-cycle strobe: a bank-restore instruction executed |
| ovf_en_i | input | 1 | 1 enables the bank overflow exception |
| bank_cnt_o | output | CNT_W | Number of banks holding saved context |
| full_o | output | 1 | All banks occupied |
| empty_o | output | 1 | No bank occupied |
| ufl_req_o | output | 1 | Bank underflow exception request pulse |
| ovf_req_o | output | 1 | Bank overflow exception request pulse |

## Verification
The hardest situation to reach from the ports is a save arriving while all banks are already occupied. Reaching it needs fifteen more saves than restores with no cancelling pairs in between, and a uniform random mix almost never gets there. The stimulus therefore runs directed fill and drain sequences first. It then runs random phases that bias the strobes heavily toward saving or toward restoring, so that the count repeatedly reaches both bounds while ovf_en_i and simultaneous strobes vary.

// File: rtl/rbt_pkg.sv
// Package: shared types for the register bank save tracker.
// Assumes nothing beyond standard SystemVerilog.
package rbt_pkg;

    // Net operation requested in one cycle, decoded from the two strobes.
    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SAVE    = 2'b01,
        OP_RESTORE = 2'b10,
        OP_CANCEL  = 2'b11
    } bank_op_e;

    // Width needed to hold the values 0..n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rbt_op_decode.sv
// Module: rbt_op_decode
// Turns the save and restore strobes into one net operation per cycle.
// A cycle with both strobes becomes OP_CANCEL, which changes nothing downstream.
// Assumes the strobes are synchronous to the tracker clock.
module rbt_op_decode
    import rbt_pkg::*;
(
    input  logic     save_i,
    input  logic     restore_i,
    output bank_op_e op_o
);

    // Purpose: map the strobe pair to the net operation.
    always_comb begin
        unique case ({restore_i, save_i})
            2'b01:   op_o = OP_SAVE;
            2'b10:   op_o = OP_RESTORE;
            2'b11:   op_o = OP_CANCEL;
            default: op_o = OP_NONE;
        endcase
    end

endmodule

// File: rtl/rbt_level_counter.sv
// Module: rbt_level_counter
// Holds the number of occupied banks. The count saturates at 0 and at NUM_BANKS.
// Full and empty flags are decoded from the stored count.
// Assumes the op input is stable around the rising clock edge. Reset is synchronous, active low.
module rbt_level_counter
    import rbt_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int CNT_W     = cnt_width(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_op_e         op_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_BANKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_max;
    logic             at_zero;

    assign at_max  = (cnt_q == MAX_CNT);
    assign at_zero = (cnt_q == '0);

    // Purpose: next count; saturates at both bounds and holds on none or cancel.
    always_comb begin
        cnt_d = cnt_q;
        case (op_i)
            OP_SAVE:    if (!at_max)  cnt_d = cnt_q + 1'b1;
            OP_RESTORE: if (!at_zero) cnt_d = cnt_q - 1'b1;
            default:    cnt_d = cnt_q;
        endcase
    end

    // Purpose: count register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o   = cnt_q;
    assign full_o  = at_max;
    assign empty_o = at_zero;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);

    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full_o, empty_o}));

    // R2
    save_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SAVE && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    restore_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RESTORE && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CANCEL) |=> $stable(cnt_q));

endmodule

// File: rtl/rbt_exc_gen.sv
// Module: rbt_exc_gen
// Generates registered one-cycle exception requests.
// Underflow comes from a restore at empty. Overflow comes from a save at full while enabled.
// Assumes full and empty come from the same count register that the op acts on.
module rbt_exc_gen
    import rbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bank_op_e op_i,
    input  logic     full_i,
    input  logic     empty_i,
    input  logic     ovf_en_i,
    output logic     ufl_req_o,
    output logic     ovf_req_o
);

    logic ufl_hit;
    logic ovf_hit;

    // Purpose: detect the two fault conditions in the strobe cycle.
    always_comb begin
        ufl_hit = (op_i == OP_RESTORE) && empty_i;
        ovf_hit = (op_i == OP_SAVE) && full_i && ovf_en_i;
    end

    // Purpose: register the requests so each lasts one cycle per fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ufl_req_o <= 1'b0;
            ovf_req_o <= 1'b0;
        end else begin
            ufl_req_o <= ufl_hit;
            ovf_req_o <= ovf_hit;
        end
    end

    // R10
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SAVE && !full_i) |=> !ovf_req_o);

    // R9
    ufl_only_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_RESTORE) |=> !ufl_req_o);

endmodule

// File: rtl/bank_save_tracker.sv
// Module: bank_save_tracker (top)
// Tracks how many register banks hold saved context and raises underflow and overflow requests.
// Assumes save_i and restore_i are one-cycle strobes synchronous to clk. Reset is synchronous, active low.
module bank_save_tracker
    import rbt_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int CNT_W     = cnt_width(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_i,
    input  logic             restore_i,
    input  logic             ovf_en_i,
    output logic [CNT_W-1:0] bank_cnt_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ufl_req_o,
    output logic             ovf_req_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_BANKS);

    bank_op_e op;

    rbt_op_decode u_decode (
        .save_i    (save_i),
        .restore_i (restore_i),
        .op_o      (op)
    );

    rbt_level_counter #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .cnt_o   (bank_cnt_o),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    rbt_exc_gen u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .full_i    (full_o),
        .empty_i   (empty_o),
        .ovf_en_i  (ovf_en_i),
        .ufl_req_o (ufl_req_o),
        .ovf_req_o (ovf_req_o)
    );

    // R5
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && empty_o) |=> (ufl_req_o && bank_cnt_o == '0));

    // R6
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && full_o && ovf_en_i) |=> (ovf_req_o && bank_cnt_o == MAX_CNT));

    // R7
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && full_o && !ovf_en_i) |=> (!ovf_req_o && bank_cnt_o == MAX_CNT));

    // R8
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> (!ufl_req_o && !ovf_req_o && $stable(bank_cnt_o)));

    // R1
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (bank_cnt_o == '0 && !ufl_req_o && !ovf_req_o));

endmodule

// File: tb/bank_save_tracker_tb.sv
`timescale 1ns/1ps
module bank_save_tracker_tb;

    localparam int NUM_BANKS = 15;
    localparam int CNT_W     = $clog2(NUM_BANKS + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             save_i, restore_i, ovf_en_i;
    logic [CNT_W-1:0] bank_cnt_o;
    logic             full_o, empty_o, ufl_req_o, ovf_req_o;

    int checks = 0;
    int fails  = 0;
    int model_cnt = 0;

    always #5 clk = ~clk;

    bank_save_tracker #(.NUM_BANKS(NUM_BANKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .ovf_en_i(ovf_en_i), .bank_cnt_o(bank_cnt_o), .full_o(full_o),
        .empty_o(empty_o), .ufl_req_o(ufl_req_o), .ovf_req_o(ovf_req_o)
    );

    // Expected next count from the requirements.
    function automatic int exp_next(int c, bit s, bit r);
        if (s && !r && c < NUM_BANKS) return c + 1;
        if (r && !s && c > 0)         return c - 1;
        return c;
    endfunction

    function automatic bit exp_ufl(int c, bit s, bit r);
        return r && !s && c == 0;
    endfunction

    function automatic bit exp_ovf(int c, bit s, bit r, bit e);
        return s && !r && c == NUM_BANKS && e;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at a falling edge, then check at the next falling edge.
    task automatic cycle(bit s, bit r, bit e);
        int    nc;
        bit    eu, eo;
        string ctag, otag;
        nc = exp_next(model_cnt, s, r);
        eu = exp_ufl(model_cnt, s, r);
        eo = exp_ovf(model_cnt, s, r, e);
        if (s && r)                         ctag = "R8";
        else if (s && model_cnt == NUM_BANKS) ctag = e ? "R6" : "R7";
        else if (s)                         ctag = "R2";
        else if (r && model_cnt == 0)       ctag = "R5";
        else if (r)                         ctag = "R3";
        else                                ctag = "R2";
        if (eo)                                        otag = "R6";
        else if (s && !r && model_cnt == NUM_BANKS)    otag = "R7";
        else if (s && !r && e)                         otag = "R10";
        else                                           otag = "R9";
        save_i = s; restore_i = r; ovf_en_i = e;
        @(negedge clk);
        model_cnt = nc;
        check(ctag, int'(bank_cnt_o), nc);
        check("R4 full", int'(full_o), int'(nc == NUM_BANKS));
        check("R4 empty", int'(empty_o), int'(nc == 0));
        check(eu ? "R5" : (s && r ? "R8" : "R9"), int'(ufl_req_o), int'(eu));
        check(otag, int'(ovf_req_o), int'(eo));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pr_save;
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0; save_i = 1'b1; restore_i = 1'b0; ovf_en_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state, even with a save strobe present
        check("R1 cnt", int'(bank_cnt_o), 0);
        check("R1 empty", int'(empty_o), 1);
        check("R1 full", int'(full_o), 0);
        check("R1 ufl", int'(ufl_req_o), 0);
        check("R1 ovf", int'(ovf_req_o), 0);
        save_i = 1'b0;
        rst_n = 1'b1;
        model_cnt = 0;

        // R5 restore at empty, then R9 pulse ends, R8 cancel at empty
        cycle(0, 1, 0);
        cycle(0, 0, 0);
        cycle(1, 1, 1);
        // R10 enable below full, then fill to full (R2)
        for (int i = 0; i < NUM_BANKS; i++) cycle(1, 0, 1);
        // R7 dropped save, R6 overflow, R8 cancel at full
        cycle(1, 0, 0);
        cycle(1, 0, 1);
        cycle(0, 0, 1);
        cycle(1, 1, 1);
        // R3 drain to empty, then underflow twice back to back
        for (int i = 0; i < NUM_BANKS; i++) cycle(0, 1, 0);
        cycle(0, 1, 1);
        cycle(0, 1, 0);

        // Random phases biased toward saving or toward restoring.
        for (int ph = 0; ph < 20; ph++) begin
            pr_save = (ph % 2 == 0) ? 80 : 20;
            for (int k = 0; k < 200; k++) begin
                bit s, r, e;
                s = ($urandom % 100) < pr_save;
                r = ($urandom % 100) < (100 - pr_save);
                if (($urandom % 8) == 0) begin s = 1; r = 1; end
                e = $urandom % 2;
                cycle(s, r, e);
            end
        end
        cycle(0, 0, 0);
        finish_run();
    end

endmodule